// File: doc/BRIEF.md
# Two-Tier Round-Robin Bus Arbiter

This block decides which of six bus masters owns a shared parallel bus. Master 0 is the on-chip initiator; masters 1 to 5 are external. A per-master configuration bit places each master in either the high tier or the low tier. Each tier rotates its own service order round-robin. The low tier as a whole holds a single seat in the high tier's rotation. When that seat comes up, the low tier's own rotation names the master.

The grant is registered, so a decision appears one clock after the request. The grant moves only at a legal hand-over point: the bus is idle, or the current owner has withdrawn its request. When nobody asks for the bus, the grant rests on master 0.

Clearing the enable hands arbitration to an outside arbiter. All grant lines fall, and the on-chip initiator's request is routed to a dedicated output pin.

Top module: `tier_rr_arbiter`

## Requirements
- R1: At most one bit of `gnt_o` is high in any cycle.
- R2: Every clock edge is a decision point while `bus_idle_i` is 1 and the arbiter is enabled. At each decision point, the requesting high-tier masters are served in rising index order, wrapping around. The rotation resumes at the index just after the most recent high-tier winner.
- R3: All low-tier masters together take one seat in the high-tier rotation, placed after index 5 and before index 0. When that seat wins, the low tier picks in rising index order, resuming after its own most recent winner.
- R4: Bit i of `hi_grp_i` set to 1 places master i in the high tier, and 0 places it in the low tier. The bit is sampled on every decision.
- R5: While `bus_idle_i` is 0 and the current owner keeps its request high, `gnt_o` does not change.
- R6: One clock after a decision point at which no master requests, `gnt_o` equals 6'b000001 (parked on master 0). Reset also leaves `gnt_o` at 6'b000001.
- R7: One clock after `arb_en_i` is sampled low, `gnt_o` is all zero and stays zero while the enable is low.
- R8: While `arb_en_i` is 0, `ext_req_o` follows `req_i[0]`. While `arb_en_i` is 1, `ext_req_o` is 0.
- R9: One clock after a decision point with at least one request, the single granted master is one that was requesting at that point.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arb_en_i | input | 1 | 1 = on-chip arbitration active, 0 = external arbiter in charge |
| req_i | input | 6 | Bus requests; bit 0 is the on-chip initiator |
| hi_grp_i | input | 6 | Per-master tier select; 1 = high tier, 0 = low tier |
| bus_idle_i | input | 1 | 1 when the bus has no transaction in progress |
| gnt_o | output | 6 | One-hot (or zero) bus grants, registered |
| ext_req_o | output | 1 | On-chip initiator request forwarded to an external arbiter |

## Verification
Both rotation pointers are hidden, so a wrong pointer only shows up as a wrong grant. The first such wrong grant appears at the next decision point where two or more masters in the affected tier request together. The directed sequences therefore keep several masters requesting across a full turn of each ring, including turns where the low-tier seat wins. A bad hand-over window shows within one clock as a grant that moves while the owner still holds its request on a busy bus.

// File: rtl/arb_pkg.sv
package arb_pkg;
    localparam int unsigned ARB_MASTERS = 6;
    localparam int unsigned ARB_PARK    = 0;

    // Advance a ring index by one with wrap at ring size n.
    function automatic int unsigned ring_next(input int unsigned idx, input int unsigned n);
        ring_next = (idx + 1 >= n) ? 0 : idx + 1;
    endfunction
endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
    parameter int unsigned N  = 6,
    parameter int unsigned PW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  act,
    input  logic [PW-1:0] ptr,
    output logic          hit,
    output logic [PW-1:0] idx
);
    // Scan from ptr upward with wrap; first active entry wins.
    always_comb begin
        int unsigned pos;
        hit = 1'b0;
        idx = '0;
        for (int unsigned k = 0; k < N; k++) begin
            pos = int'(ptr) + k;
            if (pos >= N) pos = pos - N;
            if (!hit && act[pos]) begin
                hit = 1'b1;
                idx = PW'(pos);
            end
        end
    end
endmodule

// File: rtl/tier_rr_arbiter.sv
module tier_rr_arbiter #(
    parameter int unsigned NUM_M = arb_pkg::ARB_MASTERS,
    localparam int unsigned HN   = NUM_M + 1,
    localparam int unsigned HPW  = $clog2(HN),
    localparam int unsigned LPW  = (NUM_M > 1) ? $clog2(NUM_M) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arb_en_i,
    input  logic [NUM_M-1:0] req_i,
    input  logic [NUM_M-1:0] hi_grp_i,
    input  logic             bus_idle_i,
    output logic [NUM_M-1:0] gnt_o,
    output logic             ext_req_o
);
    typedef struct packed {
        logic [NUM_M-1:0] gnt;
        logic [HPW-1:0]   hptr;
        logic [LPW-1:0]   lptr;
    } arb_state_t;

    localparam logic [NUM_M-1:0] PARK_GNT = NUM_M'(1) << arb_pkg::ARB_PARK;

    arb_state_t st_d, st_q;

    logic [NUM_M-1:0] hreq, lreq;
    logic [HN-1:0]    hi_act;
    logic             hi_hit, lo_hit;
    logic [HPW-1:0]   hi_idx;
    logic [LPW-1:0]   lo_idx;
    logic             owner_req, may_switch;

    assign hreq   = req_i & hi_grp_i;
    assign lreq   = req_i & ~hi_grp_i;
    assign hi_act = {|lreq, hreq};

    rr_pick #(.N(HN), .PW(HPW)) u_hi_ring (
        .act (hi_act),
        .ptr (st_q.hptr),
        .hit (hi_hit),
        .idx (hi_idx)
    );

    rr_pick #(.N(NUM_M), .PW(LPW)) u_lo_ring (
        .act (lreq),
        .ptr (st_q.lptr),
        .hit (lo_hit),
        .idx (lo_idx)
    );

    assign owner_req  = |(st_q.gnt & req_i);
    assign may_switch = bus_idle_i | ~owner_req;

    always_comb begin
        st_d = st_q;
        if (!arb_en_i) begin
            st_d.gnt = '0;
        end else if (may_switch) begin
            if (hi_hit) begin
                if (int'(hi_idx) == NUM_M) begin
                    st_d.gnt  = lo_hit ? (NUM_M'(1) << lo_idx) : PARK_GNT;
                    st_d.lptr = LPW'(arb_pkg::ring_next(int'(lo_idx), NUM_M));
                end else begin
                    st_d.gnt  = NUM_M'(1) << hi_idx;
                end
                st_d.hptr = HPW'(arb_pkg::ring_next(int'(hi_idx), HN));
            end else begin
                st_d.gnt = PARK_GNT;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.gnt  <= PARK_GNT;
            st_q.hptr <= '0;
            st_q.lptr <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gnt_o     = st_q.gnt;
    assign ext_req_o = ~arb_en_i & req_i[arb_pkg::ARB_PARK];
endmodule

// File: rtl/tier_rr_arbiter_chk.sv
module tier_rr_arbiter_chk #(
    parameter int unsigned NUM_M = arb_pkg::ARB_MASTERS
) (
    input logic             clk,
    input logic             rst_n,
    input logic             arb_en_i,
    input logic [NUM_M-1:0] req_i,
    input logic [NUM_M-1:0] hi_grp_i,
    input logic             bus_idle_i,
    input logic [NUM_M-1:0] gnt_o,
    input logic             ext_req_o
);
    a_r1_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));

    a_r5_hold_busy_owner: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_en_i && !bus_idle_i && (gnt_o & req_i) != '0) |=> $stable(gnt_o));

    a_r6_park_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_en_i && req_i == '0) |=> gnt_o == NUM_M'(1));

    a_r7_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !arb_en_i |=> gnt_o == '0);

    a_r8_no_ext_when_on: assert property (@(posedge clk) disable iff (!rst_n)
        arb_en_i |-> !ext_req_o);

    a_r9_grant_to_requester: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_en_i && req_i != '0 && (bus_idle_i || (gnt_o & req_i) == '0))
        |=> (gnt_o & $past(req_i)) != '0);
endmodule

bind tier_rr_arbiter tier_rr_arbiter_chk #(.NUM_M(NUM_M)) u_chk (.*);

// File: tb/sim_tier_rr_arbiter.sv
`timescale 1ns/1ps
module sim_tier_rr_arbiter;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       arb_en_i;
    logic [5:0] req_i;
    logic [5:0] hi_grp_i;
    logic       bus_idle_i;
    logic [5:0] gnt_o;
    logic       ext_req_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    tier_rr_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .arb_en_i(arb_en_i), .req_i(req_i),
        .hi_grp_i(hi_grp_i), .bus_idle_i(bus_idle_i),
        .gnt_o(gnt_o), .ext_req_o(ext_req_o)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic want_gnt(input int m, input string tag);
        logic [5:0] e;
        e = (m < 0) ? 6'b0 : (6'b1 << m);
        n_chk++;
        if (gnt_o !== e) begin
            n_fail++;
            $display("FAIL %s gnt=%b expected=%b", tag, gnt_o, e);
        end
    endtask

    task automatic want_ext(input logic e, input string tag);
        n_chk++;
        if (ext_req_o !== e) begin
            n_fail++;
            $display("FAIL %s ext_req=%b expected=%b", tag, ext_req_o, e);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; arb_en_i = 1'b1; req_i = '0; hi_grp_i = '1; bus_idle_i = 1'b1;
        repeat (2) tick();
        rst_n = 1'b1;
        #1;
        want_gnt(0, "R6 reset park");
        want_ext(1'b0, "R8 reset ext");
    endtask

    // R2: all high tier, masters 1..5 rotate
    task automatic t_high_ring();
        int seq[6] = '{1, 2, 3, 4, 5, 1};
        do_reset();
        req_i = 6'b111110;
        foreach (seq[i]) begin
            tick();
            want_gnt(seq[i], "R2 high rotation");
        end
    endtask

    // R3/R4: masters 0,1 high, 2..5 low share one seat
    task automatic t_nested_ring();
        int seq[12] = '{0, 1, 2, 0, 1, 3, 0, 1, 4, 0, 1, 5};
        do_reset();
        hi_grp_i = 6'b000011;
        req_i    = 6'b111111;
        foreach (seq[i]) begin
            tick();
            want_gnt(seq[i], "R3 nested rotation");
        end
    endtask

    // R4: everyone low tier
    task automatic t_all_low();
        int seq[3] = '{0, 5, 0};
        do_reset();
        hi_grp_i = 6'b000000;
        req_i    = 6'b100001;
        foreach (seq[i]) begin
            tick();
            want_gnt(seq[i], "R4 all low tier");
        end
    endtask

    // R5/R6/R9: hand-over only at legal points
    task automatic t_hold_and_park();
        do_reset();
        bus_idle_i = 1'b0;
        req_i = 6'b000100;
        tick(); want_gnt(2, "R9 parked owner idle req");
        req_i = 6'b001100;
        for (int i = 0; i < 3; i++) begin
            tick(); want_gnt(2, "R5 hold while busy");
        end
        req_i = 6'b001000;
        tick(); want_gnt(3, "R5 owner dropped");
        req_i = 6'b001100; bus_idle_i = 1'b1;
        tick(); want_gnt(2, "R2 wrap after idle");
        req_i = 6'b000000; bus_idle_i = 1'b0;
        tick(); want_gnt(0, "R6 park no request");
    endtask

    // R7/R8: external arbiter mode
    task automatic t_disable();
        do_reset();
        arb_en_i = 1'b0; req_i = 6'b000011;
        #1; want_ext(1'b1, "R8 forward req");
        tick(); want_gnt(-1, "R7 grants released");
        tick(); want_gnt(-1, "R7 stays released");
        req_i = 6'b000010;
        #1; want_ext(1'b0, "R8 forward no req");
        arb_en_i = 1'b1; req_i = 6'b000011;
        #1; want_ext(1'b0, "R8 enabled blocks ext");
        tick(); want_gnt(0, "R9 re-enable grant");
    endtask

    initial begin
        t_high_ring();
        t_nested_ring();
        t_all_low();
        t_hold_and_park();
        t_disable();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule